// File: doc/BRIEF.md
# Multi-Channel Sync Command Serializer

This block carries synchronisation commands between several receiver channels over a single wire. One channel is picked as master. Its copy of the block turns three kinds of event request into short serial codes on an output line, one bit per word-clock cycle: word sync, drop one IDLE and add one IDLE. When no command is being sent, the line stays low. Every code starts with a 1 that acts as a start bit, followed by two command bits.

Every other channel runs its copy in slave role. There the block watches the incoming line, decodes each code into a one-cycle pulse for the local rate matcher or word aligner, and then waits for the next start bit. A word-sync code also carries timing. The slave counts word-clock cycles from its own local sync event to the cycle in which the word-sync code completes. The aligner can then apply that count as a fixed offset so that all channels line up with the master.

Top module: `synccmd_link`

## Requirements
- R1: After reset, `line_out`, all three command pulses, `align_vld` and `align_off` are 0.
- R2: In master role with no request pending, `line_out` stays 0.
- R3: In master role, a request sampled at a clock edge when no code is in progress puts the code on `line_out`, first bit first, after that edge and the next two edges. The codes are: word sync 1,0,1; delete IDLE 1,1,0; insert IDLE 1,1,1.
- R4: Requests that arrive together are sent in the order word sync, then delete, then insert.
- R5: A request that arrives while a code is being sent is held. Held codes go out back to back, with the start bit in the cycle after the previous code's last bit. Repeated requests of one kind that are still waiting merge into a single code.
- R6: In slave role, `line_in` is sampled at each rising edge. A 1 seen while idle is the start bit, and the next two samples are the command bits. After the edge that samples the third bit, exactly one of `sync_pulse` (bits 0,1), `del_pulse` (bits 1,0) or `ins_pulse` (bits 1,1) is high for one cycle. No pulse occurs at any other time.
- R7: A code with command bits 0,0 produces no pulse. The decoder is ready for a new start bit at the very next edge.
- R8: Let `loc_wsync` be sampled high at edge e, and let a word-sync code complete at edge e+d with no other local sync in between. Then `align_vld` is high together with `sync_pulse`, and `align_off` = min(d, 2^OFF_W−1); d=0 is allowed. A word-sync code that completes with no local sync armed since the last report gives `sync_pulse` without `align_vld`.
- R9: In slave role, `line_out` is 0 and requests are discarded. In master role, `line_in` produces no pulses and no offset report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1 = master (encode), 0 = slave (decode) |
| req_wsync | input | 1 | Request a word-sync code |
| req_del | input | 1 | Request a delete-IDLE code |
| req_ins | input | 1 | Request an insert-IDLE code |
| line_out | output | 1 | Serial command line driven in master role |
| line_in | input | 1 | Serial command line received in slave role |
| loc_wsync | input | 1 | Local word-sync event pulse |
| sync_pulse | output | 1 | Decoded word-sync command |
| del_pulse | output | 1 | Decoded delete-IDLE command |
| ins_pulse | output | 1 | Decoded insert-IDLE command |
| align_off | output | OFF_W | Cycles from local sync to completed word-sync code |
| align_vld | output | 1 | `align_off` is valid this cycle |

## Verification
The encoder is driven with every non-empty set of simultaneous requests. This tells a wrong bit order or a wrong priority apart from a wrong code value. A further case adds requests during a code, including a repeated one, which separates holding from dropping and from duplicating. The decoder is fed all four start-bit-led codes, with each cycle checked, so that a missed, late or doubled pulse and the reserved code are all caught. The offset is swept from 0 past saturation in a narrow counter, and also tried with no local sync armed, to separate off-by-one counting, missing saturation and stale reports. A role test drives requests in slave role and codes in master role.

// File: rtl/synccmd_pkg.sv
package synccmd_pkg;
  localparam int CODE_LEN = 3;
  localparam int NKIND    = 3;

  typedef enum logic [1:0] {
    CMD_WSYNC = 2'd0,
    CMD_DEL   = 2'd1,
    CMD_INS   = 2'd2,
    CMD_NONE  = 2'd3
  } cmd_e;

  // serial code, bit 2 goes on the line first
  function automatic logic [CODE_LEN-1:0] cmd_bits(cmd_e c);
    case (c)
      CMD_WSYNC: cmd_bits = 3'b101;
      CMD_DEL:   cmd_bits = 3'b110;
      CMD_INS:   cmd_bits = 3'b111;
      default:   cmd_bits = 3'b000;
    endcase
  endfunction

  // mask bit 0 = word sync, 1 = delete, 2 = insert; lowest bit wins
  function automatic cmd_e pick_cmd(logic [NKIND-1:0] m);
    if (m[0])      pick_cmd = CMD_WSYNC;
    else if (m[1]) pick_cmd = CMD_DEL;
    else if (m[2]) pick_cmd = CMD_INS;
    else           pick_cmd = CMD_NONE;
  endfunction

  function automatic cmd_e decode_tail(logic b1, logic b2);
    case ({b1, b2})
      2'b01:   decode_tail = CMD_WSYNC;
      2'b10:   decode_tail = CMD_DEL;
      2'b11:   decode_tail = CMD_INS;
      default: decode_tail = CMD_NONE;
    endcase
  endfunction

  function automatic logic [NKIND-1:0] cmd_mask(cmd_e c);
    cmd_mask = (c == CMD_NONE) ? '0 : NKIND'(1) << c;
  endfunction
endpackage

// File: rtl/synccmd_enc.sv
module synccmd_enc
  import synccmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NKIND-1:0] req,
  output logic             line,
  output logic             start,
  output cmd_e             start_cmd
);
  localparam int CNT_W = $clog2(CODE_LEN);

  logic [CNT_W-1:0]    left;
  logic [CODE_LEN-2:0] tail;
  logic [NKIND-1:0]    pend;
  logic [NKIND-1:0]    want;
  logic [NKIND-1:0]    gnt;
  logic [CODE_LEN-1:0] code_w;

  assign want      = pend | req;
  assign start_cmd = pick_cmd(want);
  assign start     = en && (left == '0) && (start_cmd != CMD_NONE);
  assign gnt       = start ? cmd_mask(start_cmd) : '0;
  assign code_w    = cmd_bits(start_cmd);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      left <= '0;
      tail <= '0;
      pend <= '0;
      line <= 1'b0;
    end else begin
      pend <= want & ~gnt;
      if (left == '0) begin
        if (start) begin
          line <= code_w[CODE_LEN-1];
          tail <= code_w[CODE_LEN-2:0];
          left <= CNT_W'(CODE_LEN - 1);
        end else begin
          line <= 1'b0;
        end
      end else begin
        line <= tail[CODE_LEN-2];
        tail <= {tail[CODE_LEN-3:0], 1'b0};
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/synccmd_dec.sv
module synccmd_dec
  import synccmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             line,
  output logic [NKIND-1:0] pulse,
  output logic             ws_done
);
  localparam int CNT_W = $clog2(CODE_LEN);

  logic [CNT_W-1:0] left;
  logic             b1;
  logic             at_last;
  cmd_e             tail_cmd;

  assign at_last  = en && (left == CNT_W'(1));
  assign tail_cmd = decode_tail(b1, line);
  assign ws_done  = at_last && (tail_cmd == CMD_WSYNC);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      left  <= '0;
      b1    <= 1'b0;
      pulse <= '0;
    end else begin
      pulse <= '0;
      if (left == '0) begin
        if (line) left <= CNT_W'(CODE_LEN - 1);
      end else if (at_last) begin
        left  <= '0;
        pulse <= cmd_mask(tail_cmd);
      end else begin
        b1   <= line;
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/synccmd_offset.sv
module synccmd_offset #(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             loc,
  input  logic             hit,
  output logic [OFF_W-1:0] off,
  output logic             vld
);
  localparam logic [OFF_W-1:0] OFF_MAX = '1;

  function automatic logic [OFF_W-1:0] sat_inc(logic [OFF_W-1:0] v);
    sat_inc = (v == OFF_MAX) ? v : v + 1'b1;
  endfunction

  logic             running;
  logic [OFF_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      running <= 1'b0;
      run_cnt <= '0;
      off     <= '0;
      vld     <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (hit && (running || loc)) begin
        vld     <= 1'b1;
        off     <= loc ? '0 : run_cnt;
        running <= 1'b0;
        run_cnt <= '0;
      end else if (loc) begin
        running <= 1'b1;
        run_cnt <= OFF_W'(1);
      end else if (running) begin
        run_cnt <= sat_inc(run_cnt);
      end
    end
  end
endmodule

// File: rtl/synccmd_link.sv
module synccmd_link
  import synccmd_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_master,
  input  logic             req_wsync,
  input  logic             req_del,
  input  logic             req_ins,
  output logic             line_out,
  input  logic             line_in,
  input  logic             loc_wsync,
  output logic             sync_pulse,
  output logic             del_pulse,
  output logic             ins_pulse,
  output logic [OFF_W-1:0] align_off,
  output logic             align_vld
);
  logic             enc_line;
  logic             enc_start;
  cmd_e             enc_cmd;
  logic [NKIND-1:0] dec_pulse;
  logic             ws_done;
  logic             slave_en;
  logic [OFF_W-1:0] off_q;
  logic             vld_q;

  assign slave_en = !is_master;

  synccmd_enc u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (is_master),
    .req       ({req_ins, req_del, req_wsync}),
    .line      (enc_line),
    .start     (enc_start),
    .start_cmd (enc_cmd)
  );

  synccmd_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (slave_en),
    .line    (line_in),
    .pulse   (dec_pulse),
    .ws_done (ws_done)
  );

  synccmd_offset #(.OFF_W(OFF_W)) u_off (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (slave_en),
    .loc   (loc_wsync),
    .hit   (ws_done),
    .off   (off_q),
    .vld   (vld_q)
  );

  assign line_out   = enc_line & is_master;
  assign sync_pulse = dec_pulse[CMD_WSYNC] & slave_en;
  assign del_pulse  = dec_pulse[CMD_DEL] & slave_en;
  assign ins_pulse  = dec_pulse[CMD_INS] & slave_en;
  assign align_vld  = vld_q & slave_en;
  assign align_off  = off_q;
endmodule

// File: rtl/synccmd_chk.sv
module synccmd_chk
  import synccmd_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             is_master,
  input logic             line_out,
  input logic             loc_wsync,
  input logic             enc_start,
  input logic             enc_line,
  input logic [NKIND-1:0] dec_pulse,
  input logic             ws_done,
  input logic [OFF_W-1:0] align_off,
  input logic             align_vld
);
  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    enc_start |=> enc_line); // R3
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_pulse)); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dec_pulse) |=> (dec_pulse == '0)); // R6
  AST_VLD_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    align_vld |-> dec_pulse[CMD_WSYNC]); // R8
  AST_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_done && loc_wsync) |=> (align_vld && align_off == '0)); // R8
  AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> !line_out); // R9
endmodule

bind synccmd_link synccmd_chk #(.OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .is_master (is_master),
  .line_out  (line_out),
  .loc_wsync (loc_wsync),
  .enc_start (enc_start),
  .enc_line  (enc_line),
  .dec_pulse (dec_pulse),
  .ws_done   (ws_done),
  .align_off (align_off),
  .align_vld (align_vld)
);

// File: tb/synccmd_link_tb.sv
module synccmd_link_tb;
  localparam int OFF_W = 4;
  localparam int OMAX  = (1 << OFF_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1;
  logic req_wsync = 1'b0, req_del = 1'b0, req_ins = 1'b0;
  logic line_in = 1'b0, loc_wsync = 1'b0;
  logic line_out, sync_pulse, del_pulse, ins_pulse, align_vld;
  logic [OFF_W-1:0] align_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  synccmd_link #(.OFF_W(OFF_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .req_wsync(req_wsync), .req_del(req_del), .req_ins(req_ins),
    .line_out(line_out), .line_in(line_in), .loc_wsync(loc_wsync),
    .sync_pulse(sync_pulse), .del_pulse(del_pulse), .ins_pulse(ins_pulse),
    .align_off(align_off), .align_vld(align_vld)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // bit j (0 = first) of code kind k: ws=101, del=110, ins=111
  function automatic int code_bit(int k, int j);
    if (j == 0) return 1;
    if (j == 1) return (k != 0) ? 1 : 0;
    return (k != 1) ? 1 : 0;
  endfunction

  function automatic int pulses();
    return {29'd0, ins_pulse, del_pulse, sync_pulse};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 line_out", line_out, 0);
    check("R1 pulses", pulses(), 0);
    check("R1 align_vld", align_vld, 0);
    check("R1 align_off", align_off, 0);
    repeat (3) begin
      @(negedge clk);
      check("R2 idle line", line_out, 0);
    end

    // R3 R4: every set of simultaneous requests
    for (int m = 1; m < 8; m++) begin
      int seq[$];
      seq = {};
      for (int k = 0; k < 3; k++)
        if (m[k]) for (int j = 0; j < 3; j++) seq.push_back(code_bit(k, j));
      req_wsync = m[0]; req_del = m[1]; req_ins = m[2];
      for (int c = 0; c < seq.size(); c++) begin
        @(negedge clk);
        req_wsync = 1'b0; req_del = 1'b0; req_ins = 1'b0;
        check($sformatf("R3 R4 mask%0d bit%0d", m, c), line_out, seq[c]);
      end
      repeat (2) begin
        @(negedge clk);
        check("R2 line low after codes", line_out, 0);
      end
    end

    // R5: requests during a code are held; repeated ones merge
    begin
      int exp5[6] = '{1, 0, 1, 1, 1, 0};
      req_wsync = 1'b1;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        req_wsync = 1'b0;
        req_del = (c == 0 || c == 1);
        check($sformatf("R5 held bit%0d", c), line_out, exp5[c]);
      end
      req_del = 1'b0;
      repeat (3) begin
        @(negedge clk);
        check("R5 merged repeat", line_out, 0);
      end
    end

    // R9 master ignores line_in
    for (int t = 0; t < 5; t++) begin
      line_in = (t == 0 || t == 2);
      @(negedge clk);
      check("R9 master no pulse", pulses(), 0);
    end
    line_in = 1'b0;

    // R9 slave discards requests
    is_master = 1'b0;
    req_ins = 1'b1;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      req_ins = 1'b0;
      check("R9 slave line low", line_out, 0);
    end
    is_master = 1'b1;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      check("R9 discarded request", line_out, 0);
    end
    is_master = 1'b0;
    @(negedge clk);

    // R6 R7: all start-bit-led codes
    for (int v = 4; v < 8; v++) begin
      int ep;
      ep = (v == 5) ? 1 : (v == 6) ? 2 : (v == 7) ? 4 : 0;
      for (int t = 0; t < 5; t++) begin
        line_in = (t < 3) ? v[2 - t] : 1'b0;
        @(negedge clk);
        check($sformatf("R6 R7 code%0d t%0d", v, t), pulses(), (t == 2) ? ep : 0);
      end
    end
    // R7: reserved code followed at once by delete
    begin
      int bits[6] = '{1, 0, 0, 1, 1, 0};
      for (int t = 0; t < 8; t++) begin
        line_in = (t < 6) ? bits[t][0] : 1'b0;
        @(negedge clk);
        check($sformatf("R7 back-to-back t%0d", t), pulses(), (t == 5) ? 2 : 0);
      end
    end

    // R8: offset sweep past saturation
    for (int d = 0; d <= OMAX + 5; d++) begin
      int base, s, cc;
      base = 4; s = base + d - 2; cc = s + 2;
      for (int cyc = 0; cyc <= cc + 2; cyc++) begin
        line_in   = (cyc >= s && cyc <= cc) ? (cyc != s + 1) : 1'b0;
        loc_wsync = (cyc == base);
        @(negedge clk);
        if (cyc == cc) begin
          check($sformatf("R8 vld d%0d", d), align_vld, 1);
          check($sformatf("R8 off d%0d", d), align_off, (d > OMAX) ? OMAX : d);
          check($sformatf("R8 sync d%0d", d), sync_pulse, 1);
        end else begin
          check($sformatf("R8 quiet d%0d c%0d", d, cyc), align_vld, 0);
        end
      end
    end
    // R8: word sync with no local sync armed
    loc_wsync = 1'b0;
    for (int t = 0; t < 4; t++) begin
      line_in = (t == 0 || t == 2);
      @(negedge clk);
      if (t == 2) begin
        check("R8 unarmed sync", sync_pulse, 1);
        check("R8 unarmed no vld", align_vld, 0);
      end
    end
    line_in = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule